// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the bus clock and marks, for a separate shift engine, the exact cycles in which data is launched and captured. A law select picks between a power-of-two divider (the bus clock divided by 2^(N+1), N from 0 to 15) and a linear even divider (the bus clock divided by 2*(N+1), N from 0 to 255). The polarity bit sets the level the clock rests at, and the phase bit chooses whether capture happens on the first or the second edge of each bit, which covers SPI modes 0 to 3 ({polarity, phase} = 00, 01, 10, 11).

Settings are taken only while the enable is low: each cycle with enable low copies the divider value, law, polarity and phase into held registers, and while enable is high those inputs are ignored. When enable is low the divider counter is held at zero and the clock rests at the polarity level, so that every run starts with a full half period. All pins are plain control and status signals; there is no stream interface and therefore no back-pressure.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset sclk is 0 and both strobes are 0; while en is low, sclk equals the cpol value sampled at the previous clock edge and both strobes stay 0.
- R2: With div_law = 0 the sclk half period is 2^N bus cycles, N = div_val[3:0], giving a clock period of 2^(N+1) cycles.
- R3: With div_law = 1 the sclk half period is N+1 bus cycles, N = div_val[7:0], giving a clock period of 2*(N+1) cycles.
- R4: With div_law = 0, div_val[7:4] has no effect on the clock.
- R5: Changes on div_val, div_law, cpol and cpha while en is high have no effect; the values present in the last cycle with en low stay in force.
- R6: The counter restarts from zero each time en is sampled high after being low: with half period H, the k-th sclk edge of the run appears in the cycle after the (k*H)-th clock edge that samples en high.
- R7: The first edge of a run (and every odd edge) moves sclk away from the cpol level; every even edge returns it to cpol.
- R8: With cpha = 0, sample_stb marks the leading (odd) edges and shift_stb marks the trailing (even) edges.
- R9: With cpha = 1, shift_stb marks the leading edges and sample_stb marks the trailing edges.
- R10: Each strobe is high for exactly the one cycle in which sclk first shows its new level, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; settings are captured while low |
| div_val | input | 8 | Divider value N |
| div_law | input | 1 | 0 = power-of-two law, 1 = linear even law |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| sclk | output | 1 | Serial clock |
| shift_stb | output | 1 | One-cycle mark of a launch edge |
| sample_stb | output | 1 | One-cycle mark of a capture edge |

## Verification
Every output is registered, so each result is due one bus clock after the edge that causes it: a setting copied while en is low shows on sclk in the next cycle, and an sclk edge with its strobe appears in the cycle after the (k*H)-th edge that sampled en high. The bench keeps a count of edges seen with en high and the held settings, updated at the rising edge, and compares sclk and both strobes against closed-form values from that count at every falling edge, so each comparison lands in the cycle the result is due. Inputs change only at falling edges, right after the comparison.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  // Width able to hold the largest half-period minus one of either law.
  function automatic int half_width(input int exp_w, input int div_w);
    int pw;
    pw = 1 << exp_w;
    return (pw > div_w + 1) ? pw : div_w + 1;
  endfunction
endpackage

// File: rtl/sclk_cfg_hold.sv
module sclk_cfg_hold
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4,
  parameter int HW    = half_width(EXP_W, DIV_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_law,
  input  logic             cpol,
  input  logic             cpha,
  output logic [HW-1:0]    limit_q,
  output logic             cpol_q,
  output logic             cpha_q
);
  logic [HW-1:0] limit_d;

  always_comb begin
    if (div_law_e'(div_law) == LAW_POW2)
      limit_d = (HW'(1) << div_val[EXP_W-1:0]) - HW'(1);
    else
      limit_d = HW'(div_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
    end else if (!en) begin
      limit_q <= limit_d;
      cpol_q  <= cpol;
      cpha_q  <= cpha;
    end
  end

  // R5: held settings frozen while running
  a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(limit_q) && $stable(cpol_q) && $stable(cpha_q)));
endmodule

// File: rtl/sclk_tick_ctr.sv
module sclk_tick_ctr #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] limit,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = en && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + HW'(1);
  end

  // R6: counter restarts at zero for every run
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  // R6: counter never passes the held limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic cpol_q,
  input  logic cpha_q,
  output logic sclk,
  output logic shift_stb,
  output logic sample_stb
);
  logic active;   // 1 = away from idle level
  logic lead_q;
  logic trail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!en) begin
      active  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= tick && !active;
      trail_q <= tick && active;
      if (tick) active <= !active;
    end
  end

  assign sclk       = cpol_q ^ active;
  assign shift_stb  = cpha_q ? lead_q  : trail_q;
  assign sample_stb = cpha_q ? trail_q : lead_q;

  // R10: never both strobes at once
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_stb && sample_stb));
  // R7: a leading edge leaves the idle level, a trailing edge returns
  a_r7_lead_level: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> (sclk != cpol_q));
  a_r7_trail_level: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> (sclk == cpol_q));
  // R10: every change of sclk during a run is marked by a strobe
  a_r10_edge_marked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (sclk != $past(sclk))) |-> (lead_q || trail_q));
  // R1: idle output rests at polarity level
  a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!shift_stb && !sample_stb));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_law,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             shift_stb,
  output logic             sample_stb
);
  localparam int HW = half_width(EXP_W, DIV_W);

  logic [HW-1:0] limit_q;
  logic          cpol_q;
  logic          cpha_q;
  logic          tick;

  sclk_cfg_hold #(.DIV_W(DIV_W), .EXP_W(EXP_W), .HW(HW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val), .div_law(div_law),
    .cpol(cpol), .cpha(cpha), .limit_q(limit_q), .cpol_q(cpol_q), .cpha_q(cpha_q)
  );

  sclk_tick_ctr #(.HW(HW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .limit(limit_q), .tick(tick)
  );

  sclk_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cpol_q(cpol_q),
    .cpha_q(cpha_q), .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );
endmodule

// File: tb/tb_spi_sclk_gen.sv
module tb_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic       div_law = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, shift_stb, sample_stb;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // model state, updated at rising edges
  int unsigned t_m = 0;
  int unsigned h_m = 1;
  logic cpol_m = 1'b0;
  logic cpha_m = 1'b0;

  always #4 clk = ~clk;

  spi_sclk_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_val(div_val), .div_law(div_law),
    .cpol(cpol), .cpha(cpha), .sclk(sclk), .shift_stb(shift_stb),
    .sample_stb(sample_stb)
  );

  function automatic int unsigned half_of(input logic law, input logic [7:0] n);
    if (!law) return 32'd1 << n[3:0];
    return 32'(n) + 32'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_m <= 0; h_m <= 1; cpol_m <= 1'b0; cpha_m <= 1'b0;
    end else if (!en) begin
      t_m <= 0; h_m <= half_of(div_law, div_val); cpol_m <= cpol; cpha_m <= cpha;
    end else begin
      t_m <= t_m + 1;
    end
  end

  task automatic check_now();
    int unsigned k;
    logic edge_now, lead, trail, e_sclk, e_shift, e_sample;
    k = t_m / h_m;
    edge_now = (t_m != 0) && (t_m % h_m == 0);
    lead  = edge_now && k[0];
    trail = edge_now && !k[0];
    e_sclk   = cpol_m ^ k[0];
    e_shift  = cpha_m ? lead : trail;
    e_sample = cpha_m ? trail : lead;
    checks++;
    if (sclk !== e_sclk || shift_stb !== e_shift || sample_stb !== e_sample) begin
      errors++;
      $display("FAIL %s t=%0d H=%0d: sclk/shift/sample actual %b%b%b expected %b%b%b",
               tag, t_m, h_m, sclk, shift_stb, sample_stb, e_sclk, e_shift, e_sample);
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic burst(input string tg, input logic law, input logic [7:0] n,
                       input logic pol, input logic pha, input int len);
    tag = tg;
    en = 1'b0; div_law = law; div_val = n; cpol = pol; cpha = pha;
    run(2);
    en = 1'b1;
    run(len);
    en = 1'b0;
    run(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (sclk !== 1'b0 || shift_stb !== 1'b0 || sample_stb !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b%b%b expected 000", sclk, shift_stb, sample_stb);
    end
    rst_n = 1'b1;
    cpol = 1'b1;
    run(3);                                   // R1 idle follows cpol
    burst("R2", 1'b0, 8'd0, 1'b0, 1'b0, 12);  // H=1 power-of-two
    burst("R3", 1'b1, 8'd0, 1'b0, 1'b1, 12);  // H=1 linear
    burst("R2", 1'b0, 8'd3, 1'b0, 1'b0, 40);
    burst("R3", 1'b1, 8'd4, 1'b1, 1'b0, 40);  // R7 idle high
    burst("R8", 1'b1, 8'd2, 1'b0, 1'b0, 30);
    burst("R9", 1'b1, 8'd2, 1'b1, 1'b1, 30);
    burst("R4", 1'b0, 8'hF2, 1'b0, 1'b1, 30); // upper bits ignored: H=4
    burst("R3", 1'b1, 8'd255, 1'b0, 1'b0, 1030);
    burst("R6", 1'b0, 8'd15, 1'b1, 1'b0, 65540);
    // R5: change settings mid-run
    tag = "R5";
    en = 1'b0; div_law = 1'b1; div_val = 8'd3; cpol = 1'b0; cpha = 1'b0;
    run(2);
    en = 1'b1;
    run(13);
    div_val = 8'd0; div_law = 1'b0; cpol = 1'b1; cpha = 1'b1;
    run(40);
    en = 1'b0;
    run(3);
    // R6: restart after a short stop
    tag = "R6";
    en = 1'b1; run(9); en = 1'b0; run(1); en = 1'b1; run(20); en = 1'b0; run(2);
    // R10 and all: constrained random bursts
    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd1234);
    end
    for (int i = 0; i < 120; i++) begin
      logic law;
      logic [7:0] n;
      law = 1'($urandom_range(1, 0));
      n = law ? 8'($urandom_range(20, 0)) : 8'({$urandom_range(15, 0), 4'($urandom_range(5, 0))});
      burst("R10", law, n, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
            int'($urandom_range(150, 5)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule